// File: doc/BRIEF.md
# Audio Sample-Rate Detector

The block recognises the sample rate of an incoming I2S word-select stream by timing it against a free-running local oscillator. It is not a frequency meter. It compares each measurement with nine fixed rate windows and reports a small rate code, a valid flag, a lock flag and an error flag. The nine rates are 8, 11.025, 12, 16, 22.05, 24, 32, 44.1 and 48 kHz. A measurement that falls between the windows yields "no match". The detector never reports an intermediate rate.

Two strap pins set the operating mode and the bus subaddress. Strap value 3 selects automatic mode. In that mode the detected rate drives the outputs, and the host-written 3-bit rate field is overridden. Strap values 0, 1 and 2 select standard mode with subaddresses 0, 1 and 2. In standard mode the host field is passed straight through. The detector keeps running in both modes, so lock and error always reflect the word-select input.

The outputs are level status, not a stream. They carry no ready signal and apply no back-pressure. A consumer may read them in any cycle, and each value holds until the next measurement, timeout or strap/host change.

Top module: `srate_detect`

## Requirements
- R1: Rate codes are 0 to 8 for 8000, 11025, 12000, 16000, 22050, 24000, 32000, 44100 and 48000 Hz, in that ascending order. Code 15 means no match. When locked in automatic mode, `rate_code` carries the code of the input rate.
- R2: One measurement is the oscillator cycle count spanning 64 consecutive rising edges of the synchronised word-select. It matches rate i only when it lies within round(OSC_HZ*64/f_i) ± (that value*200/1e6 + 2) counts.
- R3: Lock rises only after two consecutive measurements give the same valid code. A single matching measurement does not lock.
- R4: While locked, a measurement whose code differs from the locked code drops lock, sets `rate_err` and clears `rate_valid` in automatic mode.
- R5: If no rising edge of word-select is seen for 4096 oscillator cycles, lock drops and `rate_err` is set. Before that time, lock is kept.
- R6: A measurement matching no window sets `rate_err` and leaves lock low. With a sustained off-rate input, automatic mode shows code 15 with `rate_valid` low.
- R7: With strap = 3 (automatic), `rate_code` ignores `host_rate`. It is the locked code, or 15 with `rate_valid` = 0 when unlocked.
- R8: With strap = 0, 1 or 2 (standard), `rate_code` = {0, host_rate} and `rate_valid` = 1 in the same cycle.
- R9: `bus_subaddr` equals the strap value for every strap value.
- R10: After reset, lock and error are 0. In automatic mode the outputs show code 15 with `rate_valid` = 0.
- R11: `rate_err` clears when lock is acquired and is never 1 while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws_in | input | 1 | I2S word-select, asynchronous to clk_osc |
| strap | input | 2 | Mode/subaddress strap pins (3 = automatic) |
| host_rate | input | 3 | Host-written rate field |
| rate_code | output | 4 | Reported rate code (15 = none) |
| rate_valid | output | 1 | rate_code is meaningful |
| rate_lock | output | 1 | Detector locked to one rate |
| rate_err | output | 1 | No-match, lock loss or timeout seen |
| bus_subaddr | output | 2 | Bus subaddress selected by the straps |

## Verification
The strap and host paths are combinational, so the bench changes them after a falling edge and samples one time unit later. The detector flags change in the cycle after the edge that closes a measurement. That edge arrives three cycles after word-select rises, through the two-flop synchroniser and the edge register. A measurement takes 64·OSC/f cycles, so the bench waits computed numbers of whole measurements plus a margin before it checks. For single-measurement effects it samples at windows of one or two measurements, taken well clear of any boundary. Lock loss on a rate change is caught by a watcher that samples every cycle of the transition window, because the exact straddling measurement depends on phase.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int NUM_RATES = 9;
  localparam logic [3:0] CODE_NONE = 4'hF;

  function automatic longint rate_hz(int idx);
    case (idx)
      0: return 8000;
      1: return 11025;
      2: return 12000;
      3: return 16000;
      4: return 22050;
      5: return 24000;
      6: return 32000;
      7: return 44100;
      default: return 48000;
    endcase
  endfunction

  // Nominal oscillator count over the averaging window, rounded.
  function automatic longint exp_count(longint osc, longint periods, int idx);
    longint r;
    r = rate_hz(idx);
    return (osc * periods + r / 2) / r;
  endfunction

  // +-200 ppm of the nominal count plus quantisation slack.
  function automatic longint tol_count(longint e);
    return (e * 200) / 1000000 + 2;
  endfunction
endpackage

// File: rtl/srd_ws_edge.sv
module srd_ws_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_async,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= ws_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // Two rising edges always have a low cycle between them (R2 timing base).
  assert_edge_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/srd_period_meter.sv
module srd_period_meter #(
  parameter int CNT_W   = 20,
  parameter int PERIODS = 64,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  output logic             meas_done_o,
  output logic [CNT_W-1:0] meas_cnt_o,
  output logic             timeout_o
);
  localparam int PER_W  = (PERIODS > 1) ? $clog2(PERIODS) : 1;
  localparam int IDLE_W = $clog2(TIMEOUT + 1);
  localparam logic [PER_W-1:0]  PER_LAST  = PER_W'(PERIODS - 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT - 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(TIMEOUT);

  logic              armed_q;
  logic [PER_W-1:0]  per_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic [CNT_W-1:0]  cnt_inc;

  assign cnt_inc     = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
  assign meas_done_o = rise_i && armed_q && (per_q == PER_LAST);
  assign meas_cnt_o  = cnt_q;
  assign timeout_o   = !rise_i && (idle_q == IDLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      per_q   <= '0;
      cnt_q   <= '0;
      idle_q  <= '0;
    end else if (rise_i) begin
      idle_q  <= '0;
      armed_q <= 1'b1;
      if (!armed_q || per_q == PER_LAST) begin
        per_q <= '0;
        cnt_q <= CNT_W'(1);
      end else begin
        per_q <= per_q + 1'b1;
        cnt_q <= cnt_inc;
      end
    end else begin
      if (armed_q)            cnt_q   <= cnt_inc;
      if (idle_q != IDLE_MAX) idle_q  <= idle_q + 1'b1;
      if (timeout_o)          armed_q <= 1'b0;
    end
  end

  // A finished window spans PERIODS edges, each at least two cycles apart.
  assert_window_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done_o |-> (meas_cnt_o >= CNT_W'(2 * PERIODS)));
  // A timeout can only be followed by a fresh start, never a completed window.
  assert_timeout_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !meas_done_o);
endmodule

// File: rtl/srd_rate_match.sv
module srd_rate_match #(
  parameter int unsigned OSC_HZ  = 14_725_000,
  parameter int          PERIODS = 64,
  parameter int          CNT_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_done_i,
  input  logic [CNT_W-1:0] meas_cnt_i,
  output logic [3:0]       code_o
);
  import srd_pkg::*;

  logic [NUM_RATES-1:0] hit;
  logic [63:0]          m64;

  assign m64 = 64'(meas_cnt_i);

  generate
    for (genvar i = 0; i < NUM_RATES; i++) begin : g_win
      localparam logic [63:0] EXP_C = 64'(exp_count(longint'(OSC_HZ), longint'(PERIODS), i));
      localparam logic [63:0] TOL_C = 64'(tol_count(exp_count(longint'(OSC_HZ), longint'(PERIODS), i)));
      assign hit[i] = (m64 + TOL_C >= EXP_C) && (m64 <= EXP_C + TOL_C);
    end
  endgenerate

  always_comb begin
    code_o = CODE_NONE;
    for (int i = NUM_RATES - 1; i >= 0; i--)
      if (hit[i]) code_o = 4'(i);
  end

  // The nine acceptance windows never overlap (R1).
  assert_windows_disjoint_R1: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done_i |-> $onehot0(hit));
endmodule

// File: rtl/srd_lock_track.sv
module srd_lock_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_done_i,
  input  logic [3:0] code_i,
  input  logic       timeout_i,
  output logic       lock_o,
  output logic [3:0] det_code_o,
  output logic       err_o
);
  import srd_pkg::*;

  logic [3:0] cand_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o     <= 1'b0;
      err_o      <= 1'b0;
      cand_q     <= CODE_NONE;
      det_code_o <= CODE_NONE;
    end else if (timeout_i) begin
      lock_o <= 1'b0;
      err_o  <= 1'b1;
      cand_q <= CODE_NONE;
    end else if (meas_done_i) begin
      cand_q <= code_i;
      if (code_i == CODE_NONE) begin
        lock_o <= 1'b0;
        err_o  <= 1'b1;
      end else if (code_i == cand_q) begin
        lock_o     <= 1'b1;
        err_o      <= 1'b0;
        det_code_o <= code_i;
      end else if (lock_o) begin
        lock_o <= 1'b0;
        err_o  <= 1'b1;
      end
    end
  end

  assert_lock_after_meas_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(meas_done_i));
  assert_drop_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && meas_done_i && !timeout_i && code_i != det_code_o) |=> (!lock_o && err_o));
  assert_timeout_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_i |=> (!lock_o && err_o));
  assert_nomatch_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done_i && code_i == CODE_NONE) |=> (err_o && !lock_o));
  assert_lock_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> !err_o);
endmodule

// File: rtl/srate_detect.sv
module srate_detect #(
  parameter int unsigned OSC_HZ  = 14_725_000,
  parameter int          PERIODS = 64,
  parameter int          TIMEOUT = 4096,
  parameter int          CNT_W   = 20
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       ws_in,
  input  logic [1:0] strap,
  input  logic [2:0] host_rate,
  output logic [3:0] rate_code,
  output logic       rate_valid,
  output logic       rate_lock,
  output logic       rate_err,
  output logic [1:0] bus_subaddr
);
  import srd_pkg::*;

  logic             rise;
  logic             meas_done;
  logic [CNT_W-1:0] meas_cnt;
  logic             timeout;
  logic [3:0]       match_code;
  logic [3:0]       det_code;
  logic             auto_mode;

  srd_ws_edge #(.STAGES(2)) u_edge (
    .clk(clk_osc), .rst_n(rst_n), .ws_async(ws_in), .rise_o(rise));

  srd_period_meter #(.CNT_W(CNT_W), .PERIODS(PERIODS), .TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk_osc), .rst_n(rst_n), .rise_i(rise),
    .meas_done_o(meas_done), .meas_cnt_o(meas_cnt), .timeout_o(timeout));

  srd_rate_match #(.OSC_HZ(OSC_HZ), .PERIODS(PERIODS), .CNT_W(CNT_W)) u_match (
    .clk(clk_osc), .rst_n(rst_n), .meas_done_i(meas_done),
    .meas_cnt_i(meas_cnt), .code_o(match_code));

  srd_lock_track u_lock (
    .clk(clk_osc), .rst_n(rst_n), .meas_done_i(meas_done), .code_i(match_code),
    .timeout_i(timeout), .lock_o(rate_lock), .det_code_o(det_code), .err_o(rate_err));

  assign auto_mode   = (strap == 2'b11);
  assign bus_subaddr = strap;

  always_comb begin
    if (auto_mode) begin
      rate_valid = rate_lock;
      rate_code  = rate_lock ? det_code : CODE_NONE;
    end else begin
      rate_valid = 1'b1;
      rate_code  = {1'b0, host_rate};
    end
  end

  // A locked automatic report always names one of the nine rates (R1, R7).
  assert_code_in_range_R1: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (auto_mode && rate_valid) |-> (rate_code < 4'(NUM_RATES)));
endmodule

// File: tb/srate_detect_tb_top.sv
module srate_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OSC       = 480_000;
  localparam int PER       = 64;
  localparam int TMO       = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ws_in = 1'b0;
  logic [1:0] strap = 2'b11;
  logic [2:0] host_rate = 3'd0;
  logic [3:0] rate_code;
  logic       rate_valid, rate_lock, rate_err;
  logic [1:0] bus_subaddr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int ws_rate = 48000;
  bit ws_en = 1'b0;
  int acc = 0;
  bit watch = 1'b0;
  bit saw_drop = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  srate_detect #(.OSC_HZ(OSC), .PERIODS(PER), .TIMEOUT(TMO), .CNT_W(20)) dut_i (
    .clk_osc(clk), .rst_n(rst_n), .ws_in(ws_in), .strap(strap), .host_rate(host_rate),
    .rate_code(rate_code), .rate_valid(rate_valid), .rate_lock(rate_lock),
    .rate_err(rate_err), .bus_subaddr(bus_subaddr));

  // Word-select generator: phase accumulator, exact average rate.
  always @(negedge clk) begin
    cycles++;
    if (ws_en) begin
      acc += 2 * ws_rate;
      if (acc >= OSC) begin
        acc -= OSC;
        ws_in <= ~ws_in;
      end
    end
    if (watch && !rate_lock && rate_err) saw_drop = 1'b1;
  end

  function automatic int rate_of(int idx);
    case (idx)
      0: return 8000;   1: return 11025; 2: return 12000;
      3: return 16000;  4: return 22050; 5: return 24000;
      6: return 32000;  7: return 44100; default: return 48000;
    endcase
  endfunction

  function automatic int meas_len(int r);
    return (PER * OSC) / r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R10: reset state in automatic mode
    chk("R10 lock", int'(rate_lock), 0);
    chk("R10 err", int'(rate_err), 0);
    chk("R10 code", int'(rate_code), 15);
    chk("R10 valid", int'(rate_valid), 0);

    // R8, R9: standard modes pass host field through, subaddress follows straps
    for (int s = 0; s < 3; s++) begin
      for (int h = 0; h < 8; h++) begin
        @(negedge clk);
        strap = 2'(s);
        host_rate = 3'(h);
        #1;
        chk("R8 code", int'(rate_code), h);
        chk("R8 valid", int'(rate_valid), 1);
        chk("R9 subaddr", int'(bus_subaddr), s);
      end
    end
    @(negedge clk);
    strap = 2'b11;
    #1;
    chk("R9 subaddr auto", int'(bus_subaddr), 3);

    // R3: one measurement is not enough, two are
    ws_rate = 48000;
    ws_en = 1'b1;
    wait_cyc(1000);
    chk("R3 no lock after one", int'(rate_lock), 0);
    wait_cyc(350);
    chk("R3 lock after two", int'(rate_lock), 1);
    chk("R3 code", int'(rate_code), 8);
    chk("R11 err clear", int'(rate_err), 0);

    // R1: sweep of every supported rate
    for (int i = 0; i < 9; i++) begin
      ws_rate = rate_of(i);
      wait_cyc(4 * meas_len(ws_rate) + 100);
      chk("R1 lock", int'(rate_lock), 1);
      chk("R1 code", int'(rate_code), i);
      chk("R1 valid", int'(rate_valid), 1);
    end

    // R7: host field ignored while in automatic mode
    for (int h = 0; h < 8; h++) begin
      @(negedge clk);
      host_rate = 3'(h);
      #1;
      chk("R7 code", int'(rate_code), 8);
    end

    // R4: rate change drops lock, then relocks to the new rate
    saw_drop = 1'b0;
    watch = 1'b1;
    ws_rate = 44100;
    wait_cyc(1500);
    watch = 1'b0;
    chk("R4 lock dropped", int'(saw_drop), 1);
    wait_cyc(3 * meas_len(44100) + 100);
    chk("R4 relock code", int'(rate_code), 7);

    // R6: off-rate input never locks
    ws_rate = 40000;
    wait_cyc(4 * meas_len(40000) + 100);
    chk("R6 lock", int'(rate_lock), 0);
    chk("R6 err", int'(rate_err), 1);
    chk("R6 code", int'(rate_code), 15);
    chk("R6 valid", int'(rate_valid), 0);

    // R2: five counts off nominal is rejected, one count off is accepted
    ws_rate = 47628;
    wait_cyc(4 * meas_len(47628) + 100);
    chk("R2 reject lock", int'(rate_lock), 0);
    chk("R2 reject code", int'(rate_code), 15);
    ws_rate = 47925;
    wait_cyc(4 * meas_len(47925) + 100);
    chk("R2 accept lock", int'(rate_lock), 1);
    chk("R2 accept code", int'(rate_code), 8);

    // R5: silence kept below the limit holds lock, beyond it drops lock
    ws_en = 1'b0;
    wait_cyc(3900);
    chk("R5 held", int'(rate_lock), 1);
    wait_cyc(300);
    chk("R5 lock", int'(rate_lock), 0);
    chk("R5 err", int'(rate_err), 1);
    chk("R5 valid", int'(rate_valid), 0);

    finish_run();
  end
endmodule